// File: doc/BRIEF.md
# Paged Address Mapper with Register Save/Restore

The mapper turns a 16-bit logical CPU address into a 24-bit physical address. The top four address bits pick one of sixteen 32-bit page base registers. The remaining twelve bits are a page offset, which is added to the chosen base rather than concatenated with it. The translation is purely combinational, and the sum is cut to 24 bits. Because the base is added, a page may start at any byte, and an offset can carry into the higher address bits.

The base register file can only be filled or emptied in bulk, through an 8-bit command port. A command copies all sixteen registers to one of eight 64-byte slots in an external byte-wide SRAM, or reloads them from a slot. The SRAM is single-port, 2 KiB and read asynchronously. A sequencer moves one byte per clock and raises a busy flag while it runs. Software typically keeps several complete mappings in SRAM and switches between them with a single command write.

Top module: `page_mapper`

## Requirements
- R1: After reset, `busy`, `mem_wr` and `mem_rd` are low and every base register is zero, so `phys_addr` equals `log_addr[11:0]` zero-extended.
- R2: `phys_addr` is always `(log_addr[11:0] + base[log_addr[15:12]]) mod 2^24`, with the carry out of the offset field kept, and it follows `log_addr` in the same cycle.
- R3: A `cmd_we` strobe whose `cmd_data[7:4]` is not zero is ignored: `busy` stays low, no SRAM access happens and the registers keep their values.
- R4: An accepted command addresses 64 consecutive SRAM bytes, starting at `cmd_data[3:1] * 64` and rising by one each busy cycle. Bytes outside that slot are untouched.
- R5: When `cmd_data[0]` is 0, the command saves. `mem_wr` is high on every busy cycle, and the bytes written are register 0 through 15, each most significant byte first.
- R6: When `cmd_data[0]` is 1, the command loads. `mem_rd` is high on every busy cycle, and each byte read is shifted into the low end of the current register, four bytes per register, register 0 first. After the load each register holds exactly its four bytes, with no earlier bits left.
- R7: `busy` rises in the cycle after an accepted strobe and stays high for exactly 64 cycles. A strobe that arrives while `busy` is high is ignored.
- R8: While `busy` is low, neither `mem_wr` nor `mem_rd` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr | input | 16 | Logical CPU address |
| phys_addr | output | 24 | Translated physical address |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte: [7:4] must be zero, [3:1] slot, [0] 1=load / 0=save |
| busy | output | 1 | Transfer in progress |
| mem_addr | output | 11 | SRAM byte address |
| mem_wr | output | 1 | SRAM write strobe |
| mem_rd | output | 1 | SRAM read strobe |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data (same cycle as `mem_addr`) |

## Verification
Several properties are checked on every cycle: the 64-cycle busy window, the strobe exclusivity and idle silence on the SRAM port, the address stepping and slot start of each transfer, whether a command is accepted or rejected, and the stability of the translation while the mapping is idle. The byte order of a save, the shift order of a load, the complete overwrite of stale register bits and the arithmetic of the translation (including the carry into the page bits and the 24-bit wrap) are visible only as data. These are shown by the bench scenarios: random slot loads followed by random translations, a save to one slot and a load back from it after the registers have been overwritten, and crafted bases at the carry and wrap corners.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int unsigned LA_W       = 16;
  localparam int unsigned PA_W       = 24;
  localparam int unsigned BASE_W     = 32;
  localparam int unsigned NREG       = 16;
  localparam int unsigned MEM_AW     = 11;
  localparam int unsigned CMD_W      = 8;
  localparam int unsigned SLOT_W     = 3;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_SAVE = 2'd1,
    XF_LOAD = 2'd2
  } xfer_e;
endpackage

// File: rtl/pgmap_regfile.sv
module pgmap_regfile #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned BASE_W = 32,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned BYTES  = BASE_W / 8,
  localparam int unsigned LANE_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [IDX_W-1:0]  seq_idx,
  input  logic [LANE_W-1:0] seq_lane,
  input  logic [7:0]        shift_byte,
  output logic [7:0]        save_byte,
  input  logic [IDX_W-1:0]  xl_idx,
  output logic [BASE_W-1:0] xl_base
);
  logic [BASE_W-1:0] base_q [NREG];
  logic [BASE_W-1:0] base_d [NREG];
  logic [BASE_W-1:0] seq_word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    always_comb begin
      en        = shift_en && (seq_idx == IDX_W'(g));
      base_d[g] = {base_q[g][BASE_W-9:0], shift_byte};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  base_q[g] <= '0;
      else if (en) base_q[g] <= base_d[g];
    end
  end

  always_comb begin
    seq_word  = base_q[seq_idx];
    save_byte = seq_word[8*(LANE_W'(BYTES-1) - seq_lane) +: 8];
    xl_base   = base_q[xl_idx];
  end
endmodule

// File: rtl/pgmap_xlat.sv
module pgmap_xlat #(
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned PA_W   = 24
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [BASE_W-1:0] base,
  output logic [PA_W-1:0]   phys
);
  logic [BASE_W-1:0] sum;
  always_comb begin
    sum  = BASE_W'(offset) + base;
    phys = sum[PA_W-1:0];
  end
endmodule

// File: rtl/pgmap_seq.sv
module pgmap_seq
  import pgmap_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned MEM_AW = 11,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned BYTES  = BASE_W / 8,
  localparam int unsigned LANE_W = $clog2(BYTES),
  localparam int unsigned CNT_W  = IDX_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              busy,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              shift_en,
  output logic [IDX_W-1:0]  seq_idx,
  output logic [LANE_W-1:0] seq_lane
);
  xfer_e             st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              accept;

  always_comb begin
    busy   = (st_q != XF_IDLE);
    accept = cmd_we && !busy && (cmd_data[CMD_W-1:SLOT_W+1] == '0);
    st_d   = st_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    case (st_q)
      XF_IDLE: if (accept) begin
        st_d   = cmd_data[0] ? XF_LOAD : XF_SAVE;
        slot_d = cmd_data[SLOT_W:1];
        cnt_d  = '0;
      end
      default: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NREG*BYTES-1)) st_d = XF_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XF_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    mem_addr = MEM_AW'({slot_q, cnt_q});
    mem_wr   = (st_q == XF_SAVE);
    mem_rd   = (st_q == XF_LOAD);
    shift_en = mem_rd;
    seq_idx  = cnt_q[CNT_W-1:LANE_W];
    seq_lane = cnt_q[LANE_W-1:0];
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pgmap_pkg::*;
#(
  parameter int unsigned P_LA_W   = LA_W,
  parameter int unsigned P_PA_W   = PA_W,
  parameter int unsigned P_BASE_W = BASE_W,
  parameter int unsigned P_NREG   = NREG,
  parameter int unsigned P_MEM_AW = MEM_AW,
  localparam int unsigned IDX_W   = $clog2(P_NREG),
  localparam int unsigned OFF_W   = P_LA_W - IDX_W,
  localparam int unsigned LANE_W  = $clog2(P_BASE_W / 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_LA_W-1:0]   log_addr,
  output logic [P_PA_W-1:0]   phys_addr,
  input  logic                cmd_we,
  input  logic [CMD_W-1:0]    cmd_data,
  output logic                busy,
  output logic [P_MEM_AW-1:0] mem_addr,
  output logic                mem_wr,
  output logic                mem_rd,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata
);
  logic                shift_en;
  logic [IDX_W-1:0]    seq_idx;
  logic [LANE_W-1:0]   seq_lane;
  logic [P_BASE_W-1:0] xl_base;

  pgmap_seq #(.NREG(P_NREG), .BASE_W(P_BASE_W), .MEM_AW(P_MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .busy(busy), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .shift_en(shift_en), .seq_idx(seq_idx), .seq_lane(seq_lane)
  );

  pgmap_regfile #(.NREG(P_NREG), .BASE_W(P_BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .seq_idx(seq_idx),
    .seq_lane(seq_lane), .shift_byte(mem_rdata), .save_byte(mem_wdata),
    .xl_idx(log_addr[P_LA_W-1:OFF_W]), .xl_base(xl_base)
  );

  pgmap_xlat #(.OFF_W(OFF_W), .BASE_W(P_BASE_W), .PA_W(P_PA_W)) u_xlat (
    .offset(log_addr[OFF_W-1:0]), .base(xl_base), .phys(phys_addr)
  );
endmodule

// File: rtl/pgmap_chk.sv
module pgmap_chk
  import pgmap_pkg::*;
#(
  parameter int unsigned P_LA_W   = LA_W,
  parameter int unsigned P_PA_W   = PA_W,
  parameter int unsigned P_MEM_AW = MEM_AW,
  parameter int unsigned P_XFER   = 64,
  localparam int unsigned CW      = $clog2(P_XFER)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [P_LA_W-1:0]   log_addr,
  input logic [P_PA_W-1:0]   phys_addr,
  input logic                cmd_we,
  input logic [CMD_W-1:0]    cmd_data,
  input logic                busy,
  input logic [P_MEM_AW-1:0] mem_addr,
  input logic                mem_wr,
  input logic                mem_rd
);
  logic [CW:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == (CW+1)'(P_XFER)));
  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < (CW+1)'(P_XFER)));
  // R7
  cmd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_data[7:4] == 4'd0) |=> busy);
  // R3
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_data[7:4] != 4'd0) |=> !busy);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr && !mem_rd));
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_wr ^ mem_rd));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == P_MEM_AW'($past(mem_addr) + 1'b1)));
  // R4
  slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_addr[CW-1:0] == '0 && mem_addr[CW+2:CW] == $past(cmd_data[3:1])));
  // R6
  dir_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_rd == $past(cmd_data[0])));
  // R2
  xlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(log_addr)) |-> $stable(phys_addr));
endmodule

bind page_mapper pgmap_chk #(.P_LA_W(P_LA_W), .P_PA_W(P_PA_W), .P_MEM_AW(P_MEM_AW),
  .P_XFER(P_NREG * (P_BASE_W / 8))) u_chk (.*);

// File: tb/page_mapper_tb.sv
module page_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] log_addr;
  logic [23:0] phys_addr;
  logic        cmd_we;
  logic [7:0]  cmd_data;
  logic        busy;
  logic [10:0] mem_addr;
  logic        mem_wr, mem_rd;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [2048];
  logic [31:0] exp_reg [16];
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_mapper u_dut (.*);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] = mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] xlat_exp(input logic [15:0] a);
    logic [31:0] s;
    s = {20'd0, a[11:0]} + exp_reg[a[15:12]];
    return s[23:0];
  endfunction

  task automatic model_load(input int slot);
    for (int i = 0; i < 16; i++)
      exp_reg[i] = {mem[slot*64+4*i], mem[slot*64+4*i+1], mem[slot*64+4*i+2], mem[slot*64+4*i+3]};
  endtask

  task automatic fill_slot_random(input int slot);
    for (int k = 0; k < 64; k++) mem[slot*64+k] = 8'($urandom);
  endtask

  task automatic issue_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_data = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_done(input string req, input logic [7:0] stray);
    int n = 0;
    while (busy && n < 200) begin
      if (n == 10) begin cmd_we = 1'b1; cmd_data = stray; end
      if (n == 11) cmd_we = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(req, n, 64);
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    log_addr = a; #1;
    chk(req, {8'd0, phys_addr}, {8'd0, xlat_exp(a)});
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd6011));
    rst_n = 1'b0; cmd_we = 1'b0; cmd_data = '0; log_addr = '0;
    for (int k = 0; k < 2048; k++) mem[k] = 8'($urandom);
    for (int i = 0; i < 16; i++) exp_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_wr, mem_rd}, 0);
    probe("R1 phys", 16'hA5C3);
    probe("R1 phys", 16'hFFFF);

    // R3 invalid commands ignored
    for (int t = 0; t < 6; t++) begin
      logic [7:0] bad;
      bad = {4'(1 + ($urandom % 15)), 4'($urandom)};
      issue_cmd(bad);
      chk("R3 busy stays low", busy, 0);
      chk("R3 no strobe", {mem_wr, mem_rd}, 0);
      probe("R3 regs unchanged", 16'($urandom));
    end

    // R6/R2 random loads then random translations
    for (int t = 0; t < 8; t++) begin
      int s;
      s = t;
      fill_slot_random(s);
      issue_cmd({4'd0, 3'(s), 1'b1});
      wait_done("R7 load length", 8'h13);
      model_load(s);
      for (int j = 0; j < 150; j++) probe("R6 R2 random xlat", 16'($urandom));
    end

    // R6 stale bits: all-ones then zeros-ish
    for (int k = 0; k < 64; k++) mem[3*64+k] = 8'hFF;
    for (int k = 0; k < 64; k++) mem[4*64+k] = (k % 4 == 3) ? 8'(k) : 8'h00;
    issue_cmd(8'h07); wait_done("R7 load length", 8'h21);
    issue_cmd(8'h09); wait_done("R7 load length", 8'h21);
    model_load(4);
    for (int p = 0; p < 16; p++) probe("R6 no stale bits", {4'(p), 12'h000});

    // R2 carry and wrap corners
    mem[6*64+0] = 8'h00; mem[6*64+1] = 8'h00; mem[6*64+2] = 8'h00; mem[6*64+3] = 8'h01;
    mem[6*64+8] = 8'h00; mem[6*64+9] = 8'hFF; mem[6*64+10] = 8'hFF; mem[6*64+11] = 8'hFF;
    mem[6*64+12] = 8'h12; mem[6*64+13] = 8'hFF; mem[6*64+14] = 8'hF8; mem[6*64+15] = 8'h00;
    issue_cmd(8'h0D); wait_done("R7 load length", 8'h0E);
    model_load(6);
    log_addr = 16'h0FFF; #1; chk("R2 carry into page bits", phys_addr, 24'h001000);
    log_addr = 16'h2001; #1; chk("R2 24-bit wrap", phys_addr, 24'h000000);
    log_addr = 16'h3900; #1; chk("R2 truncate high base", phys_addr, 24'h000100);

    // R5/R4 save to slot 5, stray save to slot 7 during busy ignored
    fill_slot_random(1);
    issue_cmd(8'h03); wait_done("R7 load length", 8'h00);
    model_load(1);
    begin
      logic [7:0] guard_lo, guard_hi, s7;
      guard_lo = mem[5*64-1]; guard_hi = mem[6*64]; s7 = mem[7*64+5];
      issue_cmd(8'h0A);
      wait_done("R7 save length, stray cmd ignored", 8'h0E);
      for (int i = 0; i < 16; i++)
        chk("R5 saved word order", {mem[5*64+4*i], mem[5*64+4*i+1], mem[5*64+4*i+2], mem[5*64+4*i+3]}, exp_reg[i]);
      chk("R4 byte below slot", mem[5*64-1], guard_lo);
      chk("R4 byte above slot", mem[6*64], guard_hi);
      chk("R7 stray save ignored", mem[7*64+5], s7);
    end

    // R6 round trip: overwrite regs from slot 2, reload slot 5
    fill_slot_random(2);
    issue_cmd(8'h05); wait_done("R7 load length", 8'hF1);
    model_load(2);
    probe("R6 intermediate", 16'h1234);
    issue_cmd(8'h0B); wait_done("R7 load length", 8'h00);
    model_load(1);
    for (int j = 0; j < 100; j++) probe("R6 round trip", 16'($urandom));

    // R8 idle again
    @(negedge clk);
    chk("R8 idle strobes", {busy, mem_wr, mem_rd}, 0);
    finish_run();
  end
endmodule